// File: doc/BRIEF.md
# Three-Channel Power Monitor Conversion Scheduler

This block sequences a single shared 8-bit converter over three quantities of a hot-pluggable board's power path: the voltage across the current-sense resistor, the switched output voltage and a free auxiliary input. Once every refresh period (one tenth of a second in the target system, set by a cycle-count parameter) it requests one conversion per channel. It places each returned code in that channel's result register.

The block also watches for a damaged pass switch. A sense reading above a small code threshold, taken while the switch is commanded off, raises a switch-short flag. That flag is reported and does nothing else. A test-mode input stops all conversion work so that a host can write known values into the result registers and read them back.

Top module: `hotswap_monitor_sched`

## Requirements
- R1: After reset all three result registers read 0, the switch-short flag is 0 and no conversion request is issued before the first period boundary.
- R2: A conversion round begins at the end of each period of PERIOD cycles counted from reset, so successive sense requests are exactly PERIOD cycles apart.
- R3: Within a round, requests go out in the fixed order channel code 0 (sense), 1 (source), 2 (auxiliary), with one request per channel per round.
- R4: A result register changes only when its own channel's conversion completes; the other registers keep their values at that time.
- R5: The request strobe is high for exactly one cycle, and the next request waits for the done strobe of the previous one.
- R6: While test mode is high, no request is issued and a done strobe is ignored, even if it arrives in the cycle test mode rises.
- R7: With test mode high, a host write with select 0, 1 or 2 loads sense, source or auxiliary respectively. A host write with test mode low is ignored.
- R8: A sense result above 6 taken with the switch-on input low sets the switch-short flag; a result of exactly 6 does not.
- R9: A sense result taken with the switch-on input high leaves the switch-short flag unchanged.
- R10: The switch-short flag clears on a later sense result at or below 6 taken with the switch off.
- R11: After test mode falls, the next round begins at the next period boundary on the grid counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Freezes conversion and enables host writes |
| sw_on | input | 1 | High while the pass switch is commanded on |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 2 | Channel of the current request (0 sense, 1 source, 2 auxiliary) |
| adc_done | input | 1 | One-cycle conversion-complete strobe |
| adc_data | input | 8 | Code returned with adc_done |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| sense_q | output | 8 | Sense result |
| source_q | output | 8 | Source result |
| aux_q | output | 8 | Auxiliary result |
| fet_short | output | 1 | Switch-short flag |

## Verification
The two functions that can fall in the same cycle are the capture of a completed conversion and the entry into test mode. The bench takes over the converter model after a sense request. It then raises the done strobe with a new code in the same cycle that test mode rises. The case passes if the sense register still holds the value the host wrote earlier and the switch-short flag has not moved. A second collision follows, where a host write lands just after test mode falls, and the bench judges it the same way, by the unchanged register.

// File: rtl/hotswap_monitor_sched.sv
module hotswap_monitor_sched #(
  parameter int DW        = 8,
  parameter int PERIOD    = 20_000_000,
  parameter int FET_LIMIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          sw_on,
  output logic          adc_start,
  output logic [1:0]    adc_chan,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] sense_q,
  output logic [DW-1:0] source_q,
  output logic [DW-1:0] aux_q,
  output logic          fet_short
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [1:0] CH_SENSE = 2'd0, CH_SRC = 2'd1, CH_AUX = 2'd2;

  typedef enum logic [1:0] {IDLE, REQ, WAIT} st_t;

  st_t          state;
  logic [CW-1:0] per_cnt;
  logic [1:0]   chan;

  wire tick    = per_cnt == LAST;
  wire capture = state == WAIT && adc_done && !test_mode;
  wire hwrite  = test_mode && host_we;

  assign adc_start = state == REQ && !test_mode;
  assign adc_chan  = chan;

  always_ff @(posedge clk) begin
    if (!rst_n)    per_cnt <= '0;
    else if (tick) per_cnt <= '0;
    else           per_cnt <= per_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      chan  <= CH_SENSE;
    end else if (test_mode) begin
      state <= IDLE;
    end else begin
      case (state)
        IDLE: if (tick) begin
          state <= REQ;
          chan  <= CH_SENSE;
        end
        REQ:  state <= WAIT;
        WAIT: if (adc_done) begin
          if (chan == CH_AUX) state <= IDLE;
          else begin
            state <= REQ;
            chan  <= chan + 2'd1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q  <= '0;
      source_q <= '0;
      aux_q    <= '0;
    end else if (capture) begin
      case (chan)
        CH_SENSE: sense_q  <= adc_data;
        CH_SRC:   source_q <= adc_data;
        CH_AUX:   aux_q    <= adc_data;
        default:  ;
      endcase
    end else if (hwrite) begin
      case (host_sel)
        CH_SENSE: sense_q  <= host_wdata;
        CH_SRC:   source_q <= host_wdata;
        CH_AUX:   aux_q    <= host_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fet_short <= 1'b0;
    else if (capture && chan == CH_SENSE && !sw_on)
      fet_short <= adc_data > DW'(FET_LIMIT);
  end

  // R5: request strobe lasts one cycle
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R6: test mode freezes the result registers except for host writes
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !host_we) |=> $stable(sense_q) && $stable(source_q) && $stable(aux_q));

  // R4: no completion and no host write means no register change
  a_r4_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_done && !host_we) |=> $stable(aux_q) && $stable(source_q) && $stable(sense_q));

  // R9: readings with the switch on never move the flag
  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sw_on |=> $stable(fet_short));

  // R6: no request while test mode is high
  a_r6_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(test_mode) && test_mode |-> !adc_start);
endmodule

// File: tb/sim_hotswap_monitor_sched.sv
`timescale 1ns/1ps
module sim_hotswap_monitor_sched;
  localparam int P = 400;
  logic clk = 0, rst_n = 0;
  logic test_mode = 0, sw_on = 0, host_we = 0;
  logic [1:0] host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic adc_start, adc_done, fet_short;
  logic [1:0] adc_chan;
  logic [7:0] adc_data, sense_q, source_q, aux_q;

  logic model_en = 1, mdl_done = 0, man_done = 0;
  logic [7:0] mdl_data = 0, man_data = 0;
  logic [7:0] val [3];
  int lat = 0; logic [1:0] pch = 0;
  int cyc = 0, checks = 0, errors = 0;
  int start_cnt [3], done_cnt [3], last_start [3];
  logic [5:0] seq = 0;

  assign adc_done = model_en ? mdl_done : man_done;
  assign adc_data = model_en ? mdl_data : man_data;

  hotswap_monitor_sched #(.DW(8), .PERIOD(P), .FET_LIMIT(6)) u0 (
    .clk, .rst_n, .test_mode, .sw_on, .adc_start, .adc_chan, .adc_done, .adc_data,
    .host_we, .host_sel, .host_wdata, .sense_q, .source_q, .aux_q, .fet_short);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int i = 0; i < 3; i++) begin
      start_cnt[i] = 0; done_cnt[i] = 0; last_start[i] = 0; val[i] = 0;
    end
  end

  always @(negedge clk) begin
    if (mdl_done) mdl_done <= 0;
    if (adc_start) begin
      start_cnt[adc_chan] <= start_cnt[adc_chan] + 1;
      last_start[adc_chan] <= cyc;
      seq <= {seq[3:0], adc_chan};
      lat <= 2; pch <= adc_chan;
    end else if (lat == 1) begin
      lat <= 0;
      if (model_en) begin
        mdl_done <= 1; mdl_data <= val[pch];
        done_cnt[pch] <= done_cnt[pch] + 1;
      end
    end else if (lat > 1) lat <= lat - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input int ch, input int n);
    while (done_cnt[ch] <= n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 sense", sense_q, 0); chk("R1 source", source_q, 0);
    chk("R1 aux", aux_q, 0); chk("R1 flag", fet_short, 0);
    chk("R1 no start", start_cnt[0], 0);
  endtask

  task automatic t_round;
    int n;
    val[0] = 10; val[1] = 20; val[2] = 30; sw_on = 1;
    wait_done(2, 0);
    chk("R3 order", seq, 6'b00_01_10);
    chk("R3 one per round", start_cnt[1], 1);
    chk("R2 sense", sense_q, 10); chk("R2 source", source_q, 20); chk("R2 aux", aux_q, 30);
    n = last_start[0];
    val[0] = 11; val[1] = 21; val[2] = 31;
    while (sense_q != 11) @(negedge clk);
    chk("R2 period", last_start[0] - n, P);
    chk("R4 source held", source_q, 20); chk("R4 aux held", aux_q, 30);
    wait_done(2, 1);
    chk("R4 source new", source_q, 21); chk("R4 aux new", aux_q, 31);
  endtask

  task automatic t_flag;
    sw_on = 0; val[0] = 6;
    wait_done(0, done_cnt[0]);
    chk("R8 limit 6", fet_short, 0);
    val[0] = 7;
    wait_done(0, done_cnt[0]);
    chk("R8 above limit", fet_short, 1);
    sw_on = 1; val[0] = 0;
    wait_done(0, done_cnt[0]);
    chk("R9 switch on", fet_short, 1);
    sw_on = 0; val[0] = 6;
    wait_done(0, done_cnt[0]);
    chk("R10 clear", fet_short, 0);
    sw_on = 1; val[0] = 200;
    wait_done(0, done_cnt[0]);
    chk("R9 high reading", fet_short, 0);
  endtask

  task automatic t_test;
    int s;
    wait_done(2, done_cnt[2]);
    test_mode = 1;
    @(negedge clk);
    host_we = 1;
    host_sel = 0; host_wdata = 8'hA5; @(negedge clk);
    host_sel = 1; host_wdata = 8'h5A; @(negedge clk);
    host_sel = 2; host_wdata = 8'h3C; @(negedge clk);
    host_sel = 3; host_wdata = 8'hFF; @(negedge clk);
    host_we = 0;
    chk("R7 sense", sense_q, 8'hA5); chk("R7 source", source_q, 8'h5A);
    chk("R7 aux", aux_q, 8'h3C);
    s = start_cnt[0] + start_cnt[1] + start_cnt[2];
    repeat (2 * P) @(negedge clk);
    chk("R6 no start", start_cnt[0] + start_cnt[1] + start_cnt[2], s);
    chk("R6 held", sense_q, 8'hA5);
  endtask

  task automatic t_exit;
    int t0;
    t0 = last_start[0] % P;
    while ((cyc - t0) % P != P / 2) @(negedge clk);
    test_mode = 0;
    host_we = 1; host_sel = 1; host_wdata = 8'h11;
    @(negedge clk);
    host_we = 0;
    @(negedge clk);
    chk("R7 write ignored", source_q, 8'h5A);
    val[0] = 1; val[1] = 2; val[2] = 3;
    wait_done(0, done_cnt[0]);
    chk("R11 boundary", (last_start[0] - t0) % P, 0);
  endtask

  task automatic t_collide;
    int n;
    wait_done(2, done_cnt[2]);
    test_mode = 1;
    host_we = 1; host_sel = 0; host_wdata = 8'h42; @(negedge clk);
    host_we = 0; test_mode = 0;
    model_en = 0; sw_on = 0;
    n = start_cnt[0];
    while (start_cnt[0] == n) @(negedge clk);
    repeat (2) @(negedge clk);
    man_done = 1; man_data = 8'h77; test_mode = 1;
    @(negedge clk);
    man_done = 0;
    @(negedge clk);
    chk("R6 done ignored", sense_q, 8'h42);
    chk("R6 flag kept", fet_short, 0);
    test_mode = 0; model_en = 1;
  endtask

  initial begin
    fork
      begin
        t_reset; t_round; t_flag; t_test; t_exit; t_collide;
      end
      begin
        repeat (150000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule